// File: doc/BRIEF.md
# Last-Level Data Array Line Read Sequencer

This block sits in front of a large, unclocked last-level cache data array. It serves two clients, the instruction-side and the data-side second-level caches. Each client posts a line read with a set index, a way and the chunk that holds its critical byte. When the sequencer is free it grants one request. It fires a single read strobe together with that request's index and way, and captures the whole 128-byte line once the array's fixed access time has passed.

The captured line goes back as a burst of four 32-byte beats on one return bus. The burst starts with the critical chunk and wraps around the line. Every beat carries first and last markers and a select bit that tells the two caches which of them owns the beat. The instruction side has fixed priority. A client that is not granted keeps its request asserted and is served once the current line has been fully delivered. Only one access is in flight at any time, so a new read starts at most once every nine cycles.

Top module: `lla_read_seq`

## Requirements
- R1: After reset, and until a request is granted, `arr_rd_stb` and `rsp_vld` are low.
- R2: When the sequencer is free and a request is valid, the request is granted in the same cycle. In that cycle `arr_rd_stb` is high and `arr_set` and `arr_way` carry the granted request's index and way. At most one grant is high in any cycle.
- R3: If both requests are valid in a cycle where the sequencer is free, the instruction side is granted and the data side is not.
- R4: Once a read has been strobed, no further grant or strobe occurs until the cycle after the last beat of that line. A read strobed in cycle n therefore allows the next strobe in cycle n+9 at the earliest. An ungranted request is simply held; it is not lost.
- R5: `arr_line` is sampled at the fourth rising edge after the edge that samples the strobe. Its value at any other edge has no effect.
- R6: The beats are presented in the four consecutive cycles n+5 to n+8, where n is the strobe cycle. Each beat is 256 bits wide.
- R7: Beat k carries line chunk (c+k) mod 4, where c is the request's chunk field (byte-offset bits [6:5]). Chunk j occupies bits [256*j+255 : 256*j] of `arr_line`.
- R8: `rsp_first` is high on the first beat only, and `rsp_last` is high on the fourth beat only.
- R9: `rsp_dside` is 0 on every beat of an instruction-side line and 1 on every beat of a data-side line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req_vld | input | 1 | Instruction-side read request valid |
| i_req_set | input | SET_W | Instruction-side set index |
| i_req_way | input | WAY_W | Instruction-side way |
| i_req_chunk | input | 2 | Instruction-side critical chunk (byte offset bits [6:5]) |
| i_req_gnt | output | 1 | Instruction-side request accepted this cycle |
| d_req_vld | input | 1 | Data-side read request valid |
| d_req_set | input | SET_W | Data-side set index |
| d_req_way | input | WAY_W | Data-side way |
| d_req_chunk | input | 2 | Data-side critical chunk |
| d_req_gnt | output | 1 | Data-side request accepted this cycle |
| arr_rd_stb | output | 1 | Array read strobe |
| arr_set | output | SET_W | Array index, valid with the strobe |
| arr_way | output | WAY_W | Array way, valid with the strobe |
| arr_line | input | 1024 | Line read from the array |
| rsp_vld | output | 1 | Return beat valid |
| rsp_data | output | 256 | Return beat data |
| rsp_first | output | 1 | First beat of a line |
| rsp_last | output | 1 | Last beat of a line |
| rsp_dside | output | 1 | Beat owner: 0 instruction side, 1 data side |

## Verification
The bench starts with a directed case in which both clients request in the same cycle with different chunks. This shows whether priority and routing are right and whether each client gets its own rotation. Random traffic with a fixed seed then mixes idle gaps, lone requests and requests that arrive while a burst is in progress. This separates an immediate grant from a held one and catches any strobe that comes too early or too late relative to the nine-cycle window. The array model drives a correct line only in the one cycle that the sequencer should sample and drives its complement in every other cycle, so a capture that is off by a single edge corrupts every beat. Random chunk values cover all four wrap starting points.

// File: rtl/lla_rs_pkg.sv
package lla_rs_pkg;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_WAIT = 2'd1,
      RS_SEND = 2'd2
   } rs_state_e;

   typedef enum logic {
      SRC_INST = 1'b0,
      SRC_DATA = 1'b1
   } rs_src_e;

endpackage

// File: rtl/lla_rs_arb.sv
module lla_rs_arb #(
   parameter int SET_W   = 10,
   parameter int WAY_W   = 4,
   parameter int CHUNK_W = 2
) (
   input  logic               free,
   input  logic               i_vld,
   input  logic [SET_W-1:0]   i_set,
   input  logic [WAY_W-1:0]   i_way,
   input  logic [CHUNK_W-1:0] i_chunk,
   input  logic               d_vld,
   input  logic [SET_W-1:0]   d_set,
   input  logic [WAY_W-1:0]   d_way,
   input  logic [CHUNK_W-1:0] d_chunk,
   output logic               i_gnt,
   output logic               d_gnt,
   output logic               stb,
   output logic [SET_W-1:0]   sel_set,
   output logic [WAY_W-1:0]   sel_way,
   output logic [CHUNK_W-1:0] sel_chunk,
   output lla_rs_pkg::rs_src_e sel_src
);
   import lla_rs_pkg::*;

   always_comb begin
      i_gnt = free & i_vld;
      d_gnt = free & d_vld & ~i_vld;
      stb   = i_gnt | d_gnt;
      if (i_vld) begin
         sel_set   = i_set;
         sel_way   = i_way;
         sel_chunk = i_chunk;
         sel_src   = SRC_INST;
      end else begin
         sel_set   = d_set;
         sel_way   = d_way;
         sel_chunk = d_chunk;
         sel_src   = SRC_DATA;
      end
   end

endmodule

// File: rtl/lla_rs_ctrl.sv
module lla_rs_ctrl #(
   parameter int CAP_LAT = 4,
   parameter int BEATS   = 4,
   localparam int CHUNK_W = $clog2(BEATS),
   localparam int CNT_W   = $clog2(CAP_LAT) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stb,
   input  lla_rs_pkg::rs_src_e src_in,
   input  logic [CHUNK_W-1:0]  chunk_in,
   output logic                free,
   output logic                cap_en,
   output logic                beat_vld,
   output logic                beat_first,
   output logic                beat_last,
   output logic [CHUNK_W-1:0]  beat_chunk,
   output lla_rs_pkg::rs_src_e beat_src
);
   import lla_rs_pkg::*;

   rs_state_e          state_q;
   logic [CNT_W-1:0]   wait_q;
   logic [CHUNK_W-1:0] idx_q;
   logic [CHUNK_W-1:0] chunk_q;
   rs_src_e            src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         wait_q  <= '0;
         idx_q   <= '0;
         chunk_q <= '0;
         src_q   <= SRC_INST;
      end else begin
         case (state_q)
            RS_IDLE: begin
               if (stb) begin
                  state_q <= RS_WAIT;
                  wait_q  <= CNT_W'(CAP_LAT - 1);
                  chunk_q <= chunk_in;
                  src_q   <= src_in;
               end
            end
            RS_WAIT: begin
               if (wait_q == '0) begin
                  state_q <= RS_SEND;
                  idx_q   <= '0;
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
            RS_SEND: begin
               idx_q   <= idx_q + 1'b1;
               chunk_q <= chunk_q + 1'b1;
               if (idx_q == CHUNK_W'(BEATS - 1)) state_q <= RS_IDLE;
            end
            default: state_q <= RS_IDLE;
         endcase
      end
   end

   always_comb begin
      free       = (state_q == RS_IDLE);
      cap_en     = (state_q == RS_WAIT) && (wait_q == '0);
      beat_vld   = (state_q == RS_SEND);
      beat_first = beat_vld && (idx_q == '0);
      beat_last  = beat_vld && (idx_q == CHUNK_W'(BEATS - 1));
      beat_chunk = chunk_q;
      beat_src   = src_q;
   end

   // R6
   capture_then_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> beat_vld && beat_first);

   // R8
   burst_opens_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(beat_vld) |-> beat_first);

   // R6
   burst_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |=> !beat_vld);

   // R7
   chunk_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_vld && !beat_last |=> beat_chunk == CHUNK_W'($past(beat_chunk) + 1'b1));

endmodule

// File: rtl/lla_rs_burst.sv
module lla_rs_burst #(
   parameter int LINE_BITS = 1024,
   parameter int BEATS     = 4,
   localparam int BEAT_BITS = LINE_BITS / BEATS,
   localparam int CHUNK_W   = $clog2(BEATS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cap_en,
   input  logic [LINE_BITS-1:0] line_in,
   input  logic [CHUNK_W-1:0]   chunk_sel,
   output logic [BEAT_BITS-1:0] beat_data
);

   logic [LINE_BITS-1:0] line_q;
   logic [BEAT_BITS-1:0] slice [BEATS];

   always_ff @(posedge clk) begin
      if (!rst_n)      line_q <= '0;
      else if (cap_en) line_q <= line_in;
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_slice
      assign slice[b] = line_q[b*BEAT_BITS +: BEAT_BITS];
   end

   assign beat_data = slice[chunk_sel];

endmodule

// File: rtl/lla_read_seq.sv
module lla_read_seq #(
   parameter int SET_W      = 10,
   parameter int WAY_W      = 4,
   parameter int LINE_BYTES = 128,
   parameter int BEATS      = 4,
   parameter int CAP_LAT    = 4,
   localparam int LINE_BITS = LINE_BYTES * 8,
   localparam int BEAT_BITS = LINE_BITS / BEATS,
   localparam int CHUNK_W   = $clog2(BEATS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 i_req_vld,
   input  logic [SET_W-1:0]     i_req_set,
   input  logic [WAY_W-1:0]     i_req_way,
   input  logic [CHUNK_W-1:0]   i_req_chunk,
   output logic                 i_req_gnt,
   input  logic                 d_req_vld,
   input  logic [SET_W-1:0]     d_req_set,
   input  logic [WAY_W-1:0]     d_req_way,
   input  logic [CHUNK_W-1:0]   d_req_chunk,
   output logic                 d_req_gnt,
   output logic                 arr_rd_stb,
   output logic [SET_W-1:0]     arr_set,
   output logic [WAY_W-1:0]     arr_way,
   input  logic [LINE_BITS-1:0] arr_line,
   output logic                 rsp_vld,
   output logic [BEAT_BITS-1:0] rsp_data,
   output logic                 rsp_first,
   output logic                 rsp_last,
   output logic                 rsp_dside
);
   import lla_rs_pkg::*;

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (LINE_BITS % BEATS != 0) begin : g_bad_line
      $error("line width must split evenly into beats");
   end
   if (CAP_LAT < 1) begin : g_bad_lat
      $error("CAP_LAT must be at least 1");
   end

   logic               free;
   logic               cap_en;
   logic               beat_vld;
   logic               beat_first;
   logic               beat_last;
   logic [CHUNK_W-1:0] beat_chunk;
   logic [CHUNK_W-1:0] sel_chunk;
   rs_src_e            sel_src;
   rs_src_e            beat_src;

   lla_rs_arb #(.SET_W(SET_W), .WAY_W(WAY_W), .CHUNK_W(CHUNK_W)) u_arb (
      .free      (free),
      .i_vld     (i_req_vld),
      .i_set     (i_req_set),
      .i_way     (i_req_way),
      .i_chunk   (i_req_chunk),
      .d_vld     (d_req_vld),
      .d_set     (d_req_set),
      .d_way     (d_req_way),
      .d_chunk   (d_req_chunk),
      .i_gnt     (i_req_gnt),
      .d_gnt     (d_req_gnt),
      .stb       (arr_rd_stb),
      .sel_set   (arr_set),
      .sel_way   (arr_way),
      .sel_chunk (sel_chunk),
      .sel_src   (sel_src)
   );

   lla_rs_ctrl #(.CAP_LAT(CAP_LAT), .BEATS(BEATS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (arr_rd_stb),
      .src_in     (sel_src),
      .chunk_in   (sel_chunk),
      .free       (free),
      .cap_en     (cap_en),
      .beat_vld   (beat_vld),
      .beat_first (beat_first),
      .beat_last  (beat_last),
      .beat_chunk (beat_chunk),
      .beat_src   (beat_src)
   );

   lla_rs_burst #(.LINE_BITS(LINE_BITS), .BEATS(BEATS)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .line_in   (arr_line),
      .chunk_sel (beat_chunk),
      .beat_data (rsp_data)
   );

   assign rsp_vld   = beat_vld;
   assign rsp_first = beat_first;
   assign rsp_last  = beat_last;
   assign rsp_dside = (beat_src == SRC_DATA);

   // R3
   iside_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd_stb && i_req_vld |-> i_req_gnt && !d_req_gnt);

   // R2
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({i_req_gnt, d_req_gnt}));

   // R4
   no_stb_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> !arr_rd_stb);

   // R4
   stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd_stb |=> !arr_rd_stb && !rsp_vld);

   // R9
   owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld && !rsp_last |=> rsp_vld && $stable(rsp_dside));

endmodule

// File: tb/lla_read_seq_test.sv
module lla_read_seq_test;
   localparam int SET_W = 10;
   localparam int WAY_W = 4;
   localparam int LB    = 1024;
   localparam int BB    = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i_req_vld = 1'b0, d_req_vld = 1'b0;
   logic [SET_W-1:0] i_req_set = '0, d_req_set = '0;
   logic [WAY_W-1:0] i_req_way = '0, d_req_way = '0;
   logic [1:0] i_req_chunk = '0, d_req_chunk = '0;
   logic i_req_gnt, d_req_gnt, arr_rd_stb;
   logic [SET_W-1:0] arr_set;
   logic [WAY_W-1:0] arr_way;
   logic [LB-1:0] arr_line;
   logic rsp_vld, rsp_first, rsp_last, rsp_dside;
   logic [BB-1:0] rsp_data;

   always #4 clk = ~clk;

   lla_read_seq uut (.*);

   // array storage model: fixed access time, correct data only in the sampling cycle
   logic [SET_W-1:0] m_set = '0;
   logic [WAY_W-1:0] m_way = '0;
   logic [3:0] m_age = 4'hF;

   function automatic logic [LB-1:0] line_of(logic [SET_W-1:0] s, logic [WAY_W-1:0] w);
      logic [LB-1:0] l;
      for (int k = 0; k < 32; k++) l[k*32 +: 32] = {6'h2A, s, w, 5'(k), 7'h35};
      return l;
   endfunction

   always @(posedge clk) begin
      if (arr_rd_stb) begin
         m_set <= arr_set; m_way <= arr_way; m_age <= 4'd0;
      end else if (m_age != 4'hF) m_age <= m_age + 4'd1;
   end

   assign arr_line = (m_age == 4'd3) ? line_of(m_set, m_way) : ~line_of(m_set, m_way);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(bit ok, string req, string what, logic [BB-1:0] act, logic [BB-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
      end
   endtask

   // bench-side expectations
   bit active = 1'b0;
   int since = 0;
   bit e_src = 1'b0;
   logic [SET_W-1:0] e_set = '0;
   logic [WAY_W-1:0] e_way = '0;
   logic [1:0] e_chunk = '0;
   bit i_took = 1'b0, d_took = 1'b0;

   task automatic cycle_check();
      bit free, exp_i, exp_d;
      int k;
      logic [1:0] c;
      if (active) since++;
      free  = !active || since >= 9;
      if (active && since >= 9) active = 1'b0;
      exp_i = free && i_req_vld;
      exp_d = free && d_req_vld && !i_req_vld;
      // R2 R3 R4
      chk(i_req_gnt == exp_i, "R3", "i_gnt", BB'(i_req_gnt), BB'(exp_i));
      chk(d_req_gnt == exp_d, "R4", "d_gnt", BB'(d_req_gnt), BB'(exp_d));
      chk(arr_rd_stb == (exp_i || exp_d), "R2", "strobe", BB'(arr_rd_stb), BB'(exp_i || exp_d));
      if (exp_i || exp_d) begin
         chk(arr_set == (exp_i ? i_req_set : d_req_set), "R2", "set", BB'(arr_set),
             BB'(exp_i ? i_req_set : d_req_set));
         chk(arr_way == (exp_i ? i_req_way : d_req_way), "R2", "way", BB'(arr_way),
             BB'(exp_i ? i_req_way : d_req_way));
      end
      if (active && since >= 5 && since <= 8) begin
         k = since - 5;
         c = e_chunk + 2'(k);
         // R6
         chk(rsp_vld == 1'b1, "R6", "rsp_vld", BB'(rsp_vld), BB'(1));
         // R5 R7
         chk(rsp_data == line_of(e_set, e_way)[c*BB +: BB], "R7", "data", rsp_data,
             line_of(e_set, e_way)[c*BB +: BB]);
         // R8
         chk(rsp_first == (k == 0), "R8", "first", BB'(rsp_first), BB'(k == 0));
         chk(rsp_last == (k == 3), "R8", "last", BB'(rsp_last), BB'(k == 3));
         // R9
         chk(rsp_dside == e_src, "R9", "dside", BB'(rsp_dside), BB'(e_src));
      end else begin
         chk(rsp_vld == 1'b0, "R6", "rsp_vld idle", BB'(rsp_vld), BB'(0));
      end
      if (exp_i || exp_d) begin
         active  = 1'b1;
         since   = 0;
         e_src   = exp_d;
         e_set   = exp_i ? i_req_set : d_req_set;
         e_way   = exp_i ? i_req_way : d_req_way;
         e_chunk = exp_i ? i_req_chunk : d_req_chunk;
      end
      i_took = i_req_gnt;
      d_took = d_req_gnt;
   endtask

   task automatic new_i();
      i_req_vld = 1'b1; i_req_set = SET_W'($urandom); i_req_way = WAY_W'($urandom);
      i_req_chunk = 2'($urandom);
   endtask
   task automatic new_d();
      d_req_vld = 1'b1; d_req_set = SET_W'($urandom); d_req_way = WAY_W'($urandom);
      d_req_chunk = 2'($urandom);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: quiet after reset
      for (int n = 0; n < 4; n++) begin
         @(negedge clk);
         chk(arr_rd_stb == 1'b0, "R1", "strobe after reset", BB'(arr_rd_stb), BB'(0));
         chk(rsp_vld == 1'b0, "R1", "rsp after reset", BB'(rsp_vld), BB'(0));
      end
      // directed: simultaneous requests, wrap start 3 and 0
      @(posedge clk); #1;
      i_req_vld = 1'b1; i_req_set = 10'h3FF; i_req_way = 4'hF; i_req_chunk = 2'd3;
      d_req_vld = 1'b1; d_req_set = 10'h001; d_req_way = 4'h0; d_req_chunk = 2'd0;
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         cycle_check();
         @(posedge clk); #1;
         if (i_req_vld && i_took) i_req_vld = 1'b0;
         if (d_req_vld && d_took) d_req_vld = 1'b0;
         if (n > 30) begin
            if (!i_req_vld && ($urandom % 12) == 0) new_i();
            if (!d_req_vld && ($urandom % 6) == 0) new_d();
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule